// File: doc/BRIEF.md
# Short-Page Effective Address Generator

This block turns the address part of a memory-reference instruction into a 32-bit effective address. It takes a 16-bit address halfword and, for one format, a second halfword. It reads one of eight 32-bit base registers or one of eight 32-bit array-page registers, and it can add a signed index value. The address halfword can be laid out in one of three ways, chosen at run time. In the plain layout, three bits pick a base register and twelve bits give the offset, so every base register covers a 4 KiB page. In the selector layout, a leading zero gives base register 0 a 32 KiB page through a 15-bit offset. In the large-page layout, a leading one picks an array-page register and takes a 28-bit offset made from both halfwords.

A request may ask for one level of indirection. The block then reads a single 32-bit pointer through a request/acknowledge read port and returns that pointer as the address. Where indexing and indirection meet, the kind of instruction decides the order. A normal instruction adds the index before the read, so it picks a pointer from a list. A scratchpad instruction adds the index to the pointer that comes back. Requests enter on a valid/ready handshake. The result leaves as a single-cycle strobe and has no back-pressure, so the consumer must take the address in the cycle it is offered. Register contents are inputs that the block only reads.

Top module: `sp_ea_gen`

## Requirements
- R1: With `fmt_sel`=0 (plain), `addr_hw[15]` requests indirection, `addr_hw[14:12]` selects a base register and `addr_hw[11:0]` is zero-extended and added to it.
- R2: With `fmt_sel`=1 (selector) and `addr_hw[15]`=0, the address is base register 0 plus the zero-extended `addr_hw[14:0]`. Indirection comes from `ind_req`.
- R3: With `fmt_sel`=1 and `addr_hw[15]`=1, `addr_hw[14:12]` selects a base register and `addr_hw[11:0]` is the offset. Indirection comes from `ind_req`.
- R4: With `fmt_sel`=2 (large page) and `addr_hw[15]`=1, `addr_hw[14:12]` selects an array-page register, and the offset is the zero-extended 28-bit value {`addr_hw[11:0]`, `ext_hw`}. With `addr_hw[15]`=0, the fields are read as in R1, except that indirection comes from `ind_req`. `ext_hw` is sampled in the same accepting cycle as `addr_hw`.
- R5: When `use_idx`=1 and there is no indirection, `idx_val` is added as a two's-complement value. All sums wrap modulo 2^32.
- R6: An indirect request issues exactly one read of a 32-bit word. With no index, the returned word is the effective address. The word is never decoded again.
- R7: For a normal instruction (`scratch_op`=0) with index and indirection, the read address already includes the index, and the returned word is the result unchanged.
- R8: For a scratchpad instruction (`scratch_op`=1) with index and indirection, the read address excludes the index, and the index is added to the returned word.
- R9: A direct request raises `ea_valid` for one cycle, in the cycle after it is accepted. An indirect request raises `mem_req` in the cycle after acceptance and raises `ea_valid` for one cycle, in the cycle after `mem_ack` is seen.
- R10: `in_ready` is low while a pointer read is pending. A request offered then is ignored and does not change the result in flight.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` does not change.
- R12: After reset, `in_ready`=1, `ea_valid`=0 and `mem_req`=0.
- R13: `fmt_sel`=3 is decoded exactly as the plain layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block can accept a request |
| fmt_sel | input | 2 | Address layout: 0 plain, 1 selector, 2 large page, 3 plain |
| addr_hw | input | 16 | Address halfword |
| ext_hw | input | 16 | Second halfword, used by the large-page layout |
| ind_req | input | 1 | Indirection request for layouts 1 and 2 |
| use_idx | input | 1 | Add the index value |
| scratch_op | input | 1 | 1 for a scratchpad instruction (index added after the pointer read) |
| idx_val | input | 32 | Index register value, two's complement |
| base_bank | input | 256 | Eight base registers, register k at bits [32k+31:32k] |
| array_bank | input | 256 | Eight array-page registers, same packing |
| mem_req | output | 1 | Pointer read request, held until acknowledged |
| mem_addr | output | 32 | Pointer read address |
| mem_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata | input | 32 | Pointer word returned |
| ea_valid | output | 1 | Effective address strobe, one cycle |
| ea_addr | output | 32 | Effective address |

## Verification
Two events can fall in the same cycle: the acknowledge that ends a pointer read, and a new request offered at the input. A request that arrives while the read is open, including in the acknowledge cycle itself, must be dropped. The bench provokes this by holding `in_valid` high with changed fields for the whole read, over random acknowledge delays. It then checks that the result still matches the first request and that only one read took place. A second overlap is between the index and the pointer read. Random mixes of `scratch_op`, `use_idx` and indirection are judged on both the read address and the final address.

// File: rtl/sp_ea_pkg.sv
package sp_ea_pkg;
  typedef enum logic [1:0] {
    FMT_PLAIN  = 2'd0,
    FMT_SELECT = 2'd1,
    FMT_LARGE  = 2'd2,
    FMT_RSVD   = 2'd3
  } fmt_e;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } ea_state_e;

  localparam int unsigned HW_W   = 16;
  localparam int unsigned PAGE_W = 12;
  localparam int unsigned WIDE_W = 15;
  localparam int unsigned LARGE_W = PAGE_W + HW_W;
endpackage

// File: rtl/sp_ea_field_dec.sv
module sp_ea_field_dec
  import sp_ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [1:0]        fmt_sel,
  input  logic [HW_W-1:0]   addr_hw,
  input  logic [HW_W-1:0]   ext_hw,
  input  logic              ind_req,
  output logic              use_arr,
  output logic [SEL_W-1:0]  reg_sel,
  output logic [ADDR_W-1:0] disp,
  output logic              ind
);
  logic             lead;
  logic [SEL_W-1:0] fld_sel;

  assign lead    = addr_hw[HW_W-1];
  assign fld_sel = addr_hw[PAGE_W +: SEL_W];

  always_comb begin
    use_arr = 1'b0;
    reg_sel = fld_sel;
    disp    = ADDR_W'(addr_hw[PAGE_W-1:0]);
    ind     = lead;
    unique case (fmt_e'(fmt_sel))
      FMT_SELECT: begin
        ind = ind_req;
        if (!lead) begin
          reg_sel = '0;
          disp    = ADDR_W'(addr_hw[WIDE_W-1:0]);
        end
      end
      FMT_LARGE: begin
        ind = ind_req;
        if (lead) begin
          use_arr = 1'b1;
          disp    = ADDR_W'({addr_hw[PAGE_W-1:0], ext_hw});
        end
      end
      default: begin
        ind = lead;
      end
    endcase
  end
endmodule

// File: rtl/sp_ea_regsel.sv
module sp_ea_regsel #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned REG_CNT = 8,
  localparam int unsigned SEL_W  = $clog2(REG_CNT)
) (
  input  logic [REG_CNT*ADDR_W-1:0] base_bank,
  input  logic [REG_CNT*ADDR_W-1:0] array_bank,
  input  logic                      use_arr,
  input  logic [SEL_W-1:0]          reg_sel,
  output logic [ADDR_W-1:0]         reg_val
);
  logic [ADDR_W-1:0] base_r [REG_CNT];
  logic [ADDR_W-1:0] arr_r  [REG_CNT];

  for (genvar k = 0; k < REG_CNT; k++) begin : g_unpack
    assign base_r[k] = base_bank[k*ADDR_W +: ADDR_W];
    assign arr_r[k]  = array_bank[k*ADDR_W +: ADDR_W];
  end

  assign reg_val = use_arr ? arr_r[reg_sel] : base_r[reg_sel];
endmodule

// File: rtl/sp_ea_sum.sv
module sp_ea_sum #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic              use_idx,
  input  logic              scratch_op,
  input  logic              ind,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] post_add
);
  logic idx_late;
  logic idx_early;

  assign idx_late   = use_idx & ind & scratch_op;
  assign idx_early  = use_idx & ~idx_late;
  assign first_addr = reg_val + disp + (idx_early ? idx_val : '0);
  assign post_add   = idx_late ? idx_val : '0;
endmodule

// File: rtl/sp_ea_ctrl.sv
module sp_ea_ctrl
  import sp_ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              need_ind,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] post_add,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr
);
  ea_state_e         st_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] post_q;
  logic [ADDR_W-1:0] ea_q;
  logic              val_q;
  logic              accept;

  assign in_ready = (st_q == ST_IDLE);
  assign accept   = in_valid & in_ready;
  assign mem_req  = (st_q == ST_FETCH);
  assign mem_addr = ptr_q;
  assign ea_valid = val_q;
  assign ea_addr  = ea_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      post_q <= '0;
      ea_q   <= '0;
      val_q  <= 1'b0;
    end else begin
      val_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (need_ind) begin
              ptr_q  <= first_addr;
              post_q <= post_add;
              st_q   <= ST_FETCH;
            end else begin
              ea_q  <= first_addr;
              val_q <= 1'b1;
            end
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            ea_q  <= mem_rdata + post_q;
            val_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R10
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  // R6
  single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req && ea_valid);

  // R9
  direct_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !need_ind |=> ea_valid && !mem_req);

  // R9
  fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && need_ind |=> mem_req && !ea_valid);
endmodule

// File: rtl/sp_ea_gen.sv
module sp_ea_gen
  import sp_ea_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned REG_CNT = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                fmt_sel,
  input  logic [15:0]               addr_hw,
  input  logic [15:0]               ext_hw,
  input  logic                      ind_req,
  input  logic                      use_idx,
  input  logic                      scratch_op,
  input  logic [ADDR_W-1:0]         idx_val,
  input  logic [REG_CNT*ADDR_W-1:0] base_bank,
  input  logic [REG_CNT*ADDR_W-1:0] array_bank,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic                      mem_ack,
  input  logic [ADDR_W-1:0]         mem_rdata,
  output logic                      ea_valid,
  output logic [ADDR_W-1:0]         ea_addr
);
  localparam int unsigned SEL_W = $clog2(REG_CNT);

  logic              use_arr;
  logic [SEL_W-1:0]  reg_sel;
  logic [ADDR_W-1:0] disp;
  logic              ind;
  logic [ADDR_W-1:0] reg_val;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] post_add;

  sp_ea_field_dec #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
    .fmt_sel (fmt_sel),
    .addr_hw (addr_hw),
    .ext_hw  (ext_hw),
    .ind_req (ind_req),
    .use_arr (use_arr),
    .reg_sel (reg_sel),
    .disp    (disp),
    .ind     (ind)
  );

  sp_ea_regsel #(.ADDR_W(ADDR_W), .REG_CNT(REG_CNT)) u_rsel (
    .base_bank  (base_bank),
    .array_bank (array_bank),
    .use_arr    (use_arr),
    .reg_sel    (reg_sel),
    .reg_val    (reg_val)
  );

  sp_ea_sum #(.ADDR_W(ADDR_W)) u_sum (
    .reg_val    (reg_val),
    .disp       (disp),
    .idx_val    (idx_val),
    .use_idx    (use_idx),
    .scratch_op (scratch_op),
    .ind        (ind),
    .first_addr (first_addr),
    .post_add   (post_add)
  );

  sp_ea_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .need_ind   (ind),
    .first_addr (first_addr),
    .post_add   (post_add),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .ea_valid   (ea_valid),
    .ea_addr    (ea_addr)
  );

  // R10
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> in_ready && !mem_req);

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !ea_valid && !mem_req);
endmodule

// File: tb/tb_sp_ea_gen.sv
module tb_sp_ea_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   fmt_sel = '0;
  logic [15:0]  addr_hw = '0;
  logic [15:0]  ext_hw = '0;
  logic         ind_req = 1'b0;
  logic         use_idx = 1'b0;
  logic         scratch_op = 1'b0;
  logic [31:0]  idx_val = '0;
  logic [255:0] base_bank = '0;
  logic [255:0] array_bank = '0;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_ack = 1'b0;
  logic [31:0]  mem_rdata = '0;
  logic         ea_valid;
  logic [31:0]  ea_addr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sp_ea_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .fmt_sel(fmt_sel), .addr_hw(addr_hw), .ext_hw(ext_hw), .ind_req(ind_req),
    .use_idx(use_idx), .scratch_op(scratch_op), .idx_val(idx_val),
    .base_bank(base_bank), .array_bank(array_bank), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ea_valid(ea_valid), .ea_addr(ea_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bank_rd(input logic [255:0] bank, input int k);
    return bank[k*32 +: 32];
  endfunction

  // Expected pointer/address, late index and indirection, per R1-style field rules
  function automatic void model(output bit need, output logic [31:0] first, output logic [31:0] post);
    logic [31:0] rv;
    logic [31:0] dv;
    bit late;
    int sel;
    sel  = int'(addr_hw[14:12]);
    rv   = bank_rd(base_bank, sel);
    dv   = {20'd0, addr_hw[11:0]};
    need = addr_hw[15];
    if (fmt_sel == 2'd1) begin
      need = ind_req;
      if (addr_hw[15] == 1'b0) begin
        rv = bank_rd(base_bank, 0);
        dv = {17'd0, addr_hw[14:0]};
      end
    end else if (fmt_sel == 2'd2) begin
      need = ind_req;
      if (addr_hw[15]) begin
        rv = bank_rd(array_bank, sel);
        dv = {4'd0, addr_hw[11:0], ext_hw};
      end
    end
    late  = use_idx && need && scratch_op;
    first = rv + dv + ((use_idx && !late) ? idx_val : 32'd0);
    post  = late ? idx_val : 32'd0;
  endfunction

  function automatic string tag_of(input bit need);
    if (need && use_idx && scratch_op) return "R8";
    if (need && use_idx) return "R7";
    if (need) return "R6";
    if (use_idx) return "R5";
    if (fmt_sel == 2'd3) return "R13";
    if (fmt_sel == 2'd1) return addr_hw[15] ? "R3" : "R2";
    if (fmt_sel == 2'd2) return "R4";
    return "R1";
  endfunction

  task automatic run_one(input logic [31:0] rd, input int delay);
    bit need;
    logic [31:0] first;
    logic [31:0] post;
    string tg;
    model(need, first, post);
    tg = tag_of(need);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (!need) begin
      chk(ea_valid === 1'b1, "R9", {31'd0, ea_valid}, 32'd1);
      chk(ea_addr === first, tg, ea_addr, first);
      chk(mem_req === 1'b0, "R9", {31'd0, mem_req}, 32'd0);
      @(negedge clk);
      chk(ea_valid === 1'b0, "R9", {31'd0, ea_valid}, 32'd0);
    end else begin
      chk(mem_req === 1'b1, "R9", {31'd0, mem_req}, 32'd1);
      chk(mem_addr === first, tg, mem_addr, first);
      chk(in_ready === 1'b0, "R10", {31'd0, in_ready}, 32'd0);
      in_valid = 1'b1;
      addr_hw  = ~addr_hw;
      idx_val  = ~idx_val;
      for (int d = 0; d < delay; d++) begin
        @(negedge clk);
        chk(mem_req === 1'b1 && mem_addr === first, "R11", mem_addr, first);
      end
      mem_ack   = 1'b1;
      mem_rdata = rd;
      @(negedge clk);
      mem_ack  = 1'b0;
      in_valid = 1'b0;
      chk(ea_valid === 1'b1, "R9", {31'd0, ea_valid}, 32'd1);
      chk(ea_addr === rd + post, tg, ea_addr, rd + post);
      chk(mem_req === 1'b0, "R6", {31'd0, mem_req}, 32'd0);
      @(negedge clk);
      chk(ea_valid === 1'b0 && mem_req === 1'b0, "R6", {30'd0, ea_valid, mem_req}, 32'd0);
    end
  endtask

  task automatic randomize_banks();
    for (int k = 0; k < 8; k++) begin
      base_bank[k*32 +: 32]  = $urandom;
      array_bank[k*32 +: 32] = $urandom;
    end
  endtask

  task automatic set_req(input logic [1:0] f, input logic [15:0] h, input logic [15:0] e,
                         input bit ir, input bit ui, input bit sc, input logic [31:0] ix);
    fmt_sel = f; addr_hw = h; ext_hw = e; ind_req = ir;
    use_idx = ui; scratch_op = sc; idx_val = ix;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4321);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(in_ready === 1'b1, "R12", {31'd0, in_ready}, 32'd1);
    chk(ea_valid === 1'b0, "R12", {31'd0, ea_valid}, 32'd0);
    chk(mem_req === 1'b0, "R12", {31'd0, mem_req}, 32'd0);

    randomize_banks();
    // R1 largest plain offset
    set_req(2'd0, 16'h7FFF, 16'h0, 1'b1, 1'b0, 1'b0, 32'd0); run_one(32'h0, 0);
    // R2 largest selector offset on register 0
    set_req(2'd1, 16'h7FFF, 16'h0, 1'b0, 1'b0, 1'b0, 32'd0); run_one(32'h0, 0);
    // R3 selector with register 5
    set_req(2'd1, 16'hD123, 16'h0, 1'b0, 1'b0, 1'b0, 32'd0); run_one(32'h0, 0);
    // R4 large page with full 28-bit offset
    set_req(2'd2, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 32'd0); run_one(32'h0, 0);
    // R5 negative index wraps
    base_bank[31:0] = 32'h0000_0010;
    set_req(2'd1, 16'h0004, 16'h0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFE0); run_one(32'h0, 0);
    // R13 reserved code acts as plain, bit 15 indirect
    set_req(2'd3, 16'hA00C, 16'h0, 1'b0, 1'b0, 1'b0, 32'd0); run_one(32'hCAFE_0000, 2);
    // R7 pre-indexed pointer
    set_req(2'd0, 16'h9010, 16'h0, 1'b0, 1'b1, 1'b0, 32'd8); run_one(32'h1234_5678, 1);
    // R8 post-indexed pointer
    set_req(2'd0, 16'h9010, 16'h0, 1'b0, 1'b1, 1'b1, 32'd8); run_one(32'h1234_5678, 3);
    // R10 a request during the fetch is dropped, including at the ack cycle
    set_req(2'd2, 16'h8001, 16'h0002, 1'b1, 1'b0, 1'b0, 32'd0); run_one(32'h0BAD_F00D, 0);

    for (int i = 0; i < 400; i++) begin
      randomize_banks();
      set_req(2'($urandom), 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), $urandom);
      run_one($urandom, int'($urandom % 5));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule